// File: doc/BRIEF.md
# Serial Programming Command Sequencer

This block is the host-side driver for a two-wire programming link: a clock line driven by the host and a data line that carries commands to the target. Each operation taken from the host is sent as one or more frames. A frame is a 4-bit command code followed by a 16-bit payload. Both fields go out least significant bit first. Data changes when the clock rises, and the target samples it when the clock falls.

Four operations are offered:
- Run a core instruction.
- Table-write a word and advance the target's address by two.
- Table-write a word and start programming.
- A helper that loads a 22-bit target address as three pairs of literal-move instructions.

A start-programming operation is followed by a no-operation frame. In that frame the fourth clock pulse is stretched, so that the host sets the programming time and the discharge time. Both times are given in system clock cycles and are sampled when the operation is accepted.

A typical write session has five steps:
1. Send core instruction 0x84A6 to enable writes.
2. Load the address.
3. Issue the increment-write for every word except the last.
4. Issue the start-programming write for the last word.
5. To continue, repeat from the address load onward.

Top module: `pgm_seq`

## Requirements
- R1: After reset the clock output and the data output are low, ready is high and done is low.
- R2: Ready is high only while no operation is in progress. An operation is accepted in a cycle where valid and ready are both high, and ready is low in the cycle that follows.
- R3: Every frame is 20 clock pulses. The first four pulses carry the command code and the remaining sixteen carry the payload, each field least significant bit first.
- R4: The data output changes only in a cycle where the clock output rises. Every pulse that is not stretched is high for HALF_CYC cycles and low for HALF_CYC cycles.
- R5: Operation code 2'b00 sends one frame: command 4'b0000 with payload op_data_i[15:0].
- R6: Operation code 2'b01 sends one frame: command 4'b1101 with payload op_data_i[15:0].
- R7: Operation code 2'b10 sends two frames. The first is command 4'b1111 with payload op_data_i[15:0]. The second is command 4'b0000 with payload 16'h0000.
- R8: In the second frame of operation 2'b10, the fourth pulse is stretched. It is high for prog_hi_cyc_i cycles and then low for prog_lo_cyc_i cycles, as sampled at acceptance. A value of zero counts as one.
- R9: Operation code 2'b11 sends six frames with command 4'b0000. Their payloads, in order, are 16'h0E00|a[21:16], 16'h6EF8, 16'h0E00|a[15:8], 16'h6EF7, 16'h0E00|a[7:0] and 16'h6EF6, where a is op_data_i.
- R10: Done is a single-cycle pulse. It rises after the last frame of an operation has fully ended, and ready is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request |
| op_ready_o | output | 1 | Sequencer idle, can accept an operation |
| op_kind_i | input | 2 | Operation code: 00 core, 01 write-increment, 10 write-start, 11 address load |
| op_data_i | input | 22 | Payload in bits [15:0], or the target address for an address load |
| prog_hi_cyc_i | input | CNT_W | Programming time in cycles (stretched high) |
| prog_lo_cyc_i | input | CNT_W | Discharge time in cycles (stretched low) |
| sclk_o | output | 1 | Programming clock |
| sdat_o | output | 1 | Programming data |
| done_o | output | 1 | Operation complete pulse |

## Verification
A monitor acts as the target. It samples data on each falling clock, rebuilds 20-bit frames and measures every pulse width. Its results are compared with frames predicted from the requirements.

Random operations with random payloads, addresses and stretch times exercise every operation code. Because the four codes differ in command value and frame count, a wrong code, a swapped field order or bits sent most significant first each show up as a frame mismatch.

Directed cases cover several corners:
- Stretch times of zero and one, which separate the clamp from an off-by-one in the stretch counter.
- An all-ones address, which catches truncation of the 6-bit upper field.
- A complete enable/load/write/start sequence, which checks that consecutive operations chain without lost or extra frames.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  localparam int CMD_W   = 4;
  localparam int PAY_W   = 16;
  localparam int FRAME_W = CMD_W + PAY_W;
  localparam int ADDR_W  = 22;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int STRETCH_BIT = 3;

  typedef enum logic [1:0] {
    OP_CORE   = 2'b00,
    OP_WR_INC = 2'b01,
    OP_WR_PGM = 2'b10,
    OP_LD_ADR = 2'b11
  } op_kind_e;

  localparam logic [CMD_W-1:0] CMD_CORE   = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_WR_INC = 4'b1101;
  localparam logic [CMD_W-1:0] CMD_WR_PGM = 4'b1111;

  typedef struct packed {
    logic             stretch;
    logic [PAY_W-1:0] pay;
    logic [CMD_W-1:0] cmd;
  } frame_t;
endpackage

// File: rtl/pgm_frame_gen.sv
module pgm_frame_gen
  import pgm_seq_pkg::*;
(
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic [2:0]        step_i,
  output frame_t            frame_o,
  output logic [2:0]        last_step_o
);
  logic [1:0] pair;
  logic [7:0] sel_byte;

  assign pair = step_i[2:1];

  always_comb begin
    unique case (pair)
      2'd0:    sel_byte = {2'b00, data_i[21:16]};
      2'd1:    sel_byte = data_i[15:8];
      default: sel_byte = data_i[7:0];
    endcase
  end

  always_comb begin
    frame_o     = '0;
    last_step_o = 3'd0;
    unique case (kind_i)
      OP_CORE: begin
        frame_o.cmd = CMD_CORE;
        frame_o.pay = data_i[PAY_W-1:0];
      end
      OP_WR_INC: begin
        frame_o.cmd = CMD_WR_INC;
        frame_o.pay = data_i[PAY_W-1:0];
      end
      OP_WR_PGM: begin
        last_step_o = 3'd1;
        if (step_i == 3'd0) begin
          frame_o.cmd = CMD_WR_PGM;
          frame_o.pay = data_i[PAY_W-1:0];
        end else begin
          frame_o.cmd     = CMD_CORE;
          frame_o.stretch = 1'b1;
        end
      end
      default: begin
        last_step_o = 3'd5;
        frame_o.cmd = CMD_CORE;
        // even step: literal move of address byte; odd step: store to pointer byte
        frame_o.pay = step_i[0] ? {8'h6E, 8'hF8 - {6'd0, pair}} : {8'h0E, sel_byte};
      end
    endcase
  end
endmodule

// File: rtl/pgm_bit_engine.sv
module pgm_bit_engine
  import pgm_seq_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  frame_t           frame_i,
  input  logic [CNT_W-1:0] hi_cyc_i,
  input  logic [CNT_W-1:0] lo_cyc_i,
  output logic             sclk_o,
  output logic             sdat_o,
  output logic             frame_done_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(HALF_CYC);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_W - 1);

  logic               busy_q, phase_hi_q, stretch_q;
  logic [IDX_W-1:0]   bit_q;
  logic [CNT_W-1:0]   cnt_q, dur;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   hi_eff, lo_eff;

  assign hi_eff = (hi_cyc_i == '0) ? CNT_W'(1) : hi_cyc_i;
  assign lo_eff = (lo_cyc_i == '0) ? CNT_W'(1) : lo_cyc_i;

  always_comb begin
    if (stretch_q && bit_q == IDX_W'(STRETCH_BIT)) dur = phase_hi_q ? hi_eff : lo_eff;
    else dur = HALF;
  end

  logic phase_end;
  assign phase_end    = busy_q && (cnt_q == dur - CNT_W'(1));
  assign frame_done_o = phase_end && !phase_hi_q && (bit_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      phase_hi_q <= 1'b0;
      stretch_q  <= 1'b0;
      bit_q      <= '0;
      cnt_q      <= '0;
      shreg_q    <= '0;
      sclk_o     <= 1'b0;
      sdat_o     <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q     <= 1'b1;
        phase_hi_q <= 1'b1;
        stretch_q  <= frame_i.stretch;
        bit_q      <= '0;
        cnt_q      <= '0;
        shreg_q    <= {frame_i.pay, frame_i.cmd};
        sclk_o     <= 1'b1;
        sdat_o     <= frame_i.cmd[0];
      end
    end else if (phase_end) begin
      cnt_q <= '0;
      if (phase_hi_q) begin
        phase_hi_q <= 1'b0;
        sclk_o     <= 1'b0;
      end else if (bit_q == LAST_BIT) begin
        busy_q <= 1'b0;
      end else begin
        bit_q      <= bit_q + IDX_W'(1);
        phase_hi_q <= 1'b1;
        shreg_q    <= shreg_q >> 1;
        sclk_o     <= 1'b1;
        sdat_o     <= shreg_q[1];
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_seq_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  output logic             op_ready_o,
  input  logic [1:0]       op_kind_i,
  input  logic [21:0]      op_data_i,
  input  logic [CNT_W-1:0] prog_hi_cyc_i,
  input  logic [CNT_W-1:0] prog_lo_cyc_i,
  output logic             sclk_o,
  output logic             sdat_o,
  output logic             done_o
);
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT} state_e;

  state_e            state_q;
  op_kind_e          kind_q;
  logic [ADDR_W-1:0] data_q;
  logic [2:0]        step_q, last_step;
  logic [CNT_W-1:0]  hi_q, lo_q;
  logic              done_q, frame_done;
  frame_t            frame;

  pgm_frame_gen u_gen (
    .kind_i      (kind_q),
    .data_i      (data_q),
    .step_i      (step_q),
    .frame_o     (frame),
    .last_step_o (last_step)
  );

  pgm_bit_engine #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (state_q == S_LAUNCH),
    .frame_i      (frame),
    .hi_cyc_i     (hi_q),
    .lo_cyc_i     (lo_q),
    .sclk_o       (sclk_o),
    .sdat_o       (sdat_o),
    .frame_done_o (frame_done)
  );

  assign op_ready_o = (state_q == S_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= OP_CORE;
      data_q  <= '0;
      step_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (op_valid_i) begin
          kind_q  <= op_kind_e'(op_kind_i);
          data_q  <= op_data_i;
          hi_q    <= prog_hi_cyc_i;
          lo_q    <= prog_lo_cyc_i;
          step_q  <= '0;
          state_q <= S_LAUNCH;
        end
        S_LAUNCH: state_q <= S_WAIT;
        default: if (frame_done) begin
          if (step_q == last_step) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q  <= step_q + 3'd1;
            state_q <= S_LAUNCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic op_valid_i,
  input logic op_ready_o,
  input logic sclk_o,
  input logic sdat_o,
  input logic done_o
);
  AST_DATA_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdat_o) |-> $rose(sclk_o)); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o |=> !op_ready_o); // R2
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ready_o |-> !sclk_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> op_ready_o && !sclk_o); // R10
endmodule

bind pgm_seq pgm_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_ready_o (op_ready_o),
  .sclk_o     (sclk_o),
  .sdat_o     (sdat_o),
  .done_o     (done_o)
);

// File: tb/sim_pgm_seq.sv
`timescale 1ns/1ps
module sim_pgm_seq;
  localparam int HALF = 2;
  localparam int CW   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic [1:0] kind = '0;
  logic [21:0] data = '0;
  logic [CW-1:0] p_hi = '0, p_lo = '0;
  logic ready, sclk, sdat, done;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pgm_seq #(.HALF_CYC(HALF), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(valid), .op_ready_o(ready),
    .op_kind_i(kind), .op_data_i(data), .prog_hi_cyc_i(p_hi), .prog_lo_cyc_i(p_lo),
    .sclk_o(sclk), .sdat_o(sdat), .done_o(done)
  );

  logic [19:0] exp_frm[$];
  bit          exp_str[$];
  int          exp_hi[$], exp_lo[$];
  string       exp_tag[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void push_frm(input logic [3:0] c, input logic [15:0] p, input bit s,
                                   input int h, input int l, input string t);
    exp_frm.push_back({p, c});
    exp_str.push_back(s);
    exp_hi.push_back(h < 1 ? 1 : h);
    exp_lo.push_back(l < 1 ? 1 : l);
    exp_tag.push_back(t);
  endfunction

  function automatic void predict(input logic [1:0] k, input logic [21:0] d, input int h, input int l);
    case (k)
      2'b00: push_frm(4'b0000, d[15:0], 0, 0, 0, "R5");
      2'b01: push_frm(4'b1101, d[15:0], 0, 0, 0, "R6");
      2'b10: begin
        push_frm(4'b1111, d[15:0], 0, 0, 0, "R7");
        push_frm(4'b0000, 16'h0000, 1, h, l, "R7");
      end
      default: begin
        push_frm(4'b0000, {8'h0E, 2'b00, d[21:16]}, 0, 0, 0, "R9");
        push_frm(4'b0000, 16'h6EF8, 0, 0, 0, "R9");
        push_frm(4'b0000, {8'h0E, d[15:8]}, 0, 0, 0, "R9");
        push_frm(4'b0000, 16'h6EF7, 0, 0, 0, "R9");
        push_frm(4'b0000, {8'h0E, d[7:0]}, 0, 0, 0, "R9");
        push_frm(4'b0000, 16'h6EF6, 0, 0, 0, "R9");
      end
    endcase
  endfunction

  // target model: samples data on falling clock, measures pulse widths
  logic        prev = 1'b0;
  int          run = 0, idx = 0;
  logic [19:0] obs;
  int          hlen[20], llen[20];

  task automatic check_frame();
    logic [19:0] ef; bit es; int eh, el; string et; bit t_ok;
    if (exp_frm.size() == 0) begin
      chk(0, "R3 unexpected frame", obs, 0);
      return;
    end
    ef = exp_frm.pop_front(); es = exp_str.pop_front();
    eh = exp_hi.pop_front(); el = exp_lo.pop_front(); et = exp_tag.pop_front();
    chk(obs == ef, {et, " R3 frame"}, obs, ef);
    t_ok = 1;
    for (int i = 0; i < 20; i++) begin
      if (!(es && i == 3)) begin
        if (hlen[i] != HALF) t_ok = 0;
        if (i < 19 && llen[i] != HALF) t_ok = 0;
      end
    end
    chk(t_ok, "R4 pulse widths", hlen[0], HALF);
    if (es) begin
      chk(hlen[3] == eh, "R8 stretched high", hlen[3], eh);
      chk(llen[3] == el, "R8 stretched low", llen[3], el);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk !== prev) begin
        if (prev) begin
          obs[idx] = sdat;
          hlen[idx] = run;
          idx++;
          if (idx == 20) begin
            check_frame();
            idx = 0;
          end
        end else if (idx > 0) begin
          llen[idx-1] = run;
        end
        run = 1;
      end else begin
        run++;
      end
      prev = sclk;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] k, input logic [21:0] d, input int h, input int l);
    predict(k, d, h, l);
    @(negedge clk);
    while (!ready) @(negedge clk);
    kind = k; data = d; p_hi = CW'(h); p_lo = CW'(l); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    kind = ~k; data = ~d; p_hi = 16'h7; p_lo = 16'h9; // changes after acceptance must not matter
    chk(ready == 1'b0, "R2 ready low after accept", ready, 0);
    while (!done) @(negedge clk);
    chk(exp_frm.size() == 0 && idx == 0, "R10 done after last frame", exp_frm.size(), 0);
    chk(ready == 1'b1, "R10 ready with done", ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    #1;
    chk(sclk == 0 && sdat == 0, "R1 lines low in reset", {sclk, sdat}, 0);
    chk(ready == 1 && done == 0, "R1 ready/done in reset", {ready, done}, 2'b10);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1 && sclk == 0 && done == 0, "R1 after reset release", {ready, sclk, done}, 3'b100);

    // full write session
    issue(2'b00, 22'h0084A6, 0, 0);            // R5
    issue(2'b11, 22'h2A5C3E, 0, 0);            // R9
    issue(2'b01, 22'h00BEEF, 0, 0);            // R6
    issue(2'b01, 22'h001234, 0, 0);            // R6
    issue(2'b10, 22'h00CAFE, 12, 7);           // R7 R8
    // stretch corners
    issue(2'b10, 22'h0000FF, 0, 0);            // R8 zero clamps to one
    issue(2'b10, 22'h00FF00, 1, 1);            // R8
    issue(2'b11, 22'h3FFFFF, 0, 0);            // R9 all-ones address
    issue(2'b11, 22'h000000, 0, 0);            // R9

    for (int n = 0; n < 30; n++) begin
      logic [1:0] rk = 2'($urandom_range(0, 3));
      logic [21:0] rd = 22'($urandom);
      issue(rk, rd, $urandom_range(0, 40), $urandom_range(0, 40));
    end

    repeat (10) @(negedge clk);
    chk(exp_frm.size() == 0, "R3 no frames left", exp_frm.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule